// File: doc/BRIEF.md
# Ping-Pong Sequencer for a Time-Multiplexed Datapath

This block is the static sequencer that stays in place while the surrounding datapath is rebuilt between processing steps. One image is handled in several passes. Each pass uses one configuration of the datapath. Between two passes the rest of the array is loaded with the next configuration. The sequencer itself is never reloaded.

Two external frame buffers hold the intermediate image. On the first pass the pixels come from the acquisition input and are stored in buffer 0. On every later pass the sequencer reads the buffer written by the previous pass and writes the other one. A single select bit names the buffer being written; the read side uses the opposite buffer.

The pass count is loaded together with the start pulse. After the last pixel of a pass, the sequencer either requests the next configuration and waits for it to be reported complete, or it ends the frame. The image size is a power of two set by the address width. The default width of 18 bits gives 512x512 pixels.

Top module: `rtr_pingpong_ctrl`

## Requirements
- R1: After reset the sequencer is idle. `rd_en`, `wr_en`, `cfg_req`, `frame_done` and `acq_sel` are low and `buf_sel` is 0. While idle, a high `pix_valid` produces no write.
- R2: A `start` pulse while idle captures the 4-bit `num_steps`, where a value of 0 is run as 1. A `start` pulse at any other time is ignored, so the captured count does not change.
- R3: During the first pass the sequencer behaves as follows:
  - `acq_sel` is high.
  - `rd_en` stays low.
  - `buf_sel` is 0.
  - `wr_en` equals `pix_valid`.
- R4: Within a pass, `wr_addr` starts at 0 and advances by one after each write (`wr_en` high). The last address is 2^ADDR_W-1, and writing it ends the pass.
- R5: On every pass after the first, `rd_en` is high for exactly 2^ADDR_W consecutive cycles starting in the first cycle of the pass, whatever `pix_valid` does. `rd_addr` runs 0,1,2,… over those cycles, and the read buffer is the one not named by `buf_sel`.
- R6: When the last write of a pass that is not the final pass occurs, `buf_sel` inverts and `cfg_req` is high in the next cycle.
- R7: `cfg_req` stays high until `cfg_done` is sampled high, but only after the first request cycle. While `cfg_req` is high, `pix_valid` produces no write and `rd_en` is low.
- R8: In the cycle after `cfg_done` is accepted, a new pass starts. In that first cycle both `wr_addr` and `rd_addr` are 0.
- R9: When the last write of the final pass occurs, `frame_done` is high for exactly one cycle and `cfg_req` stays low. During that cycle `buf_sel` still names the buffer that holds the result. The sequencer is idle in the following cycle.
- R10: A count of 15 runs 15 passes with 14 configuration requests. The buffer select alternates 0,1,0,… across the passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (honoured only when idle) |
| num_steps | input | 4 | Number of passes for the frame, 0 treated as 1 |
| pix_valid | input | 1 | A processed pixel is available for writing |
| cfg_done | input | 1 | The requested configuration has finished loading |
| rd_en | output | 1 | Read strobe for the source buffer |
| rd_addr | output | ADDR_W | Read address in the source buffer |
| wr_en | output | 1 | Write strobe for the destination buffer |
| wr_addr | output | ADDR_W | Write address in the destination buffer |
| buf_sel | output | 1 | Buffer being written; the read side uses the other one |
| acq_sel | output | 1 | High on the first pass: the datapath takes the acquisition input |
| cfg_req | output | 1 | Request to load the next datapath configuration |
| frame_done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
The bound checker watches several rules on every cycle:
- `wr_addr` advances by one per write;
- no reads occur on the acquisition pass;
- `buf_sel` changes when a request rises;
- the request is held until it is acknowledged;
- no write occurs during reconfiguration;
- `frame_done` is a single pulse that never coincides with a request.

Other properties need a whole scenario to show. These are:
- the captured pass count and the treatment of 0;
- the full read window of exactly 2^ADDR_W cycles;
- restarting both addresses at 0 after each acknowledge;
- a `start` ignored in mid-frame;
- the final select value naming the result buffer.

The bench shows these with directed runs of 1, 2, 3 and 15 passes, using gaps in `pix_valid` and varied acknowledge delays.

// File: rtl/rtr_pp_pkg.sv
package rtr_pp_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_CFG_REQ,
        ST_CFG_WAIT,
        ST_FINISH
    } ctrl_state_e;

    typedef struct packed {
        logic load;
        logic step_end;
        logic clr_addr;
        logic flip;
    } ctrl_evt_t;

    function automatic logic [STEP_W-1:0] norm_steps(input logic [STEP_W-1:0] n);
        return (n == '0) ? STEP_W'(1) : n;
    endfunction

endpackage

// File: rtl/rtr_addr_ctr.sv
module rtr_addr_ctr #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last,
    output logic              spent
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr  <= '0;
            spent <= 1'b0;
        end else if (adv && !spent) begin
            if (addr == LAST) spent <= 1'b1;
            else              addr  <= addr + 1'b1;
        end
    end

    assign at_last = (addr == LAST);
endmodule

// File: rtl/rtr_step_trk.sv
module rtr_step_trk
    import rtr_pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STEP_W-1:0] steps_in,
    input  logic              inc,
    output logic              first,
    output logic              final_step
);
    logic [STEP_W-1:0] total_q;
    logic [STEP_W-1:0] part_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= STEP_W'(1);
            part_q  <= '0;
        end else if (load) begin
            total_q <= norm_steps(steps_in);
            part_q  <= '0;
        end else if (inc) begin
            part_q  <= part_q + 1'b1;
        end
    end

    assign first      = (part_q == '0);
    assign final_step = ((part_q + STEP_W'(1)) == total_q);
endmodule

// File: rtl/rtr_buf_toggle.sv
module rtr_buf_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic flip,
    output logic sel
);
    always_ff @(posedge clk) begin
        if (rst || clr) sel <= 1'b0;
        else if (flip)  sel <= ~sel;
    end
endmodule

// File: rtl/rtr_pingpong_ctrl.sv
module rtr_pingpong_ctrl
    import rtr_pp_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] num_steps,
    input  logic              pix_valid,
    input  logic              cfg_done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              buf_sel,
    output logic              acq_sel,
    output logic              cfg_req,
    output logic              frame_done
);
    localparam int N_CTR = 2;   // index 0: read side, index 1: write side

    ctrl_state_e state_q, state_d;
    ctrl_evt_t   evt;
    logic        first, final_step;
    logic        running;

    logic [N_CTR-1:0]             ctr_adv;
    logic [N_CTR-1:0]             ctr_last;
    logic [N_CTR-1:0]             ctr_spent;
    logic [N_CTR-1:0][ADDR_W-1:0] ctr_addr;

    assign running = (state_q == ST_RUN);
    assign rd_en   = running && !first && !ctr_spent[0];
    assign wr_en   = running && pix_valid;
    assign ctr_adv = {wr_en, rd_en};
    assign rd_addr = ctr_addr[0];
    assign wr_addr = ctr_addr[1];

    always_comb begin
        evt          = '0;
        evt.load     = (state_q == ST_IDLE) && start;
        evt.step_end = wr_en && ctr_last[1];
        evt.flip     = evt.step_end && !final_step;
        evt.clr_addr = evt.load || ((state_q == ST_CFG_WAIT) && cfg_done);
    end

    generate
        for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
            rtr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
                .clk     (clk),
                .rst     (rst),
                .clr     (evt.clr_addr),
                .adv     (ctr_adv[g]),
                .addr    (ctr_addr[g]),
                .at_last (ctr_last[g]),
                .spent   (ctr_spent[g])
            );
        end
    endgenerate

    rtr_step_trk u_steps (
        .clk        (clk),
        .rst        (rst),
        .load       (evt.load),
        .steps_in   (num_steps),
        .inc        (evt.step_end),
        .first      (first),
        .final_step (final_step)
    );

    rtr_buf_toggle u_sel (
        .clk  (clk),
        .rst  (rst),
        .clr  (evt.load),
        .flip (evt.flip),
        .sel  (buf_sel)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start)        state_d = ST_RUN;
            ST_RUN:      if (evt.step_end) state_d = final_step ? ST_FINISH : ST_CFG_REQ;
            ST_CFG_REQ:                    state_d = ST_CFG_WAIT;
            ST_CFG_WAIT: if (cfg_done)     state_d = ST_RUN;
            ST_FINISH:                     state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign acq_sel    = running && first;
    assign cfg_req    = (state_q == ST_CFG_REQ) || (state_q == ST_CFG_WAIT);
    assign frame_done = (state_q == ST_FINISH);
endmodule

// File: rtl/rtr_pingpong_chk.sv
module rtr_pingpong_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_valid,
    input logic              cfg_done,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              buf_sel,
    input logic              acq_sel,
    input logic              cfg_req,
    input logic              frame_done
);
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)) || cfg_req || frame_done);

    p_no_read_first_r3: assert property (@(posedge clk) disable iff (rst)
        acq_sel |-> !rd_en);

    p_req_flips_sel_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req) |-> (buf_sel != $past(buf_sel)));

    p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_req && !cfg_done) |=> cfg_req);

    p_quiet_in_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_req |-> (!wr_en && !rd_en));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !cfg_req));

    p_done_no_req_r9: assert property (@(posedge clk) disable iff (rst)
        !(frame_done && cfg_req));

    p_write_has_valid_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_req) |-> $past(wr_en && pix_valid));
endmodule

bind rtr_pingpong_ctrl rtr_pingpong_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_valid  (pix_valid),
    .cfg_done   (cfg_done),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .buf_sel    (buf_sel),
    .acq_sel    (acq_sel),
    .cfg_req    (cfg_req),
    .frame_done (frame_done)
);

// File: tb/rtr_pingpong_ctrl_test.sv
module rtr_pingpong_ctrl_test;
    localparam int AW  = 3;
    localparam int PIX = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    num_steps = '0;
    logic          pix_valid = 1'b0;
    logic          cfg_done = 1'b0;
    logic          rd_en, wr_en, buf_sel, acq_sel, cfg_req, frame_done;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rtr_pingpong_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .num_steps(num_steps),
        .pix_valid(pix_valid), .cfg_done(cfg_done),
        .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .buf_sel(buf_sel), .acq_sel(acq_sel), .cfg_req(cfg_req),
        .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_start(input int n);
        @(negedge clk);
        start = 1'b1; num_steps = 4'(n); pix_valid = 1'b0;
    endtask

    // One pass: checks reads (R5), writes (R3/R4), and start-of-pass state (R8).
    task automatic run_step(input int exp_sel, input bit first, input bit gap);
        int c = 0;
        int w = 0;
        while (w < PIX) begin
            @(negedge clk);
            start = 1'b0; cfg_done = 1'b0;
            pix_valid = !(gap && (c % 3 == 2));
            #1;
            if (c == 0) begin
                check(buf_sel == exp_sel, "R3", "buf_sel at pass start", buf_sel, exp_sel);
                check(acq_sel == first, "R3", "acq_sel", acq_sel, first);
                check(wr_addr == 0, "R8", "wr_addr at pass start", wr_addr, 0);
                check(rd_addr == 0, "R8", "rd_addr at pass start", rd_addr, 0);
            end
            check(rd_en == (!first && c < PIX), "R5", "rd_en", rd_en, (!first && c < PIX));
            if (!first && c < PIX)
                check(rd_addr == c, "R5", "rd_addr", rd_addr, c);
            check(wr_en == pix_valid, "R4", "wr_en follows valid", wr_en, pix_valid);
            if (pix_valid) begin
                check(wr_addr == w, "R4", "wr_addr", wr_addr, w);
                w++;
            end
            c++;
        end
    endtask

    task automatic wait_cfg(input int exp_sel, input int delay);
        @(negedge clk);
        pix_valid = 1'b1; #1;
        check(cfg_req == 1'b1, "R6", "cfg_req after pass", cfg_req, 1);
        check(buf_sel == exp_sel, "R6", "buf_sel flipped", buf_sel, exp_sel);
        check(wr_en == 1'b0, "R7", "no write during reconfig", wr_en, 0);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk); #1;
            check(cfg_req == 1'b1, "R7", "cfg_req held", cfg_req, 1);
            check(wr_en == 1'b0 && rd_en == 1'b0, "R7", "quiet during wait", wr_en, 0);
        end
        @(negedge clk);
        cfg_done = 1'b1; #1;
        check(cfg_req == 1'b1, "R7", "cfg_req with done", cfg_req, 1);
    endtask

    task automatic finish_chk(input int exp_sel);
        @(negedge clk);
        pix_valid = 1'b0; #1;
        check(frame_done == 1'b1, "R9", "frame_done", frame_done, 1);
        check(cfg_req == 1'b0, "R9", "no cfg_req at end", cfg_req, 0);
        check(buf_sel == exp_sel, "R9", "result buffer", buf_sel, exp_sel);
        @(negedge clk);
        pix_valid = 1'b1; #1;
        check(frame_done == 1'b0, "R9", "frame_done one cycle", frame_done, 0);
        check(wr_en == 1'b0 && rd_en == 1'b0, "R9", "idle after frame", wr_en, 0);
        pix_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check(!rd_en && !wr_en && !cfg_req && !frame_done && !acq_sel, "R1",
              "outputs low in reset idle", {rd_en, wr_en, cfg_req, frame_done, acq_sel}, 0);
        check(buf_sel == 1'b0, "R1", "buf_sel after reset", buf_sel, 0);
        pix_valid = 1'b1; #1;
        check(wr_en == 1'b0, "R1", "valid ignored when idle", wr_en, 0);
        pix_valid = 1'b0;
    endtask

    task automatic t_single;
        do_start(1);
        run_step(0, 1'b1, 1'b0);
        finish_chk(0);
    endtask

    task automatic t_three;
        do_start(3);
        run_step(0, 1'b1, 1'b1);
        wait_cfg(1, 2);
        run_step(1, 1'b0, 1'b1);
        wait_cfg(0, 4);
        run_step(0, 1'b0, 1'b0);
        finish_chk(0);
    endtask

    task automatic t_zero_count;
        do_start(0);   // R2: zero runs as one pass
        run_step(0, 1'b1, 1'b0);
        finish_chk(0);
    endtask

    task automatic t_start_ignored;
        do_start(2);
        run_step(0, 1'b1, 1'b0);
        start = 1'b1; num_steps = 4'd9;   // R2: must be ignored mid-frame
        wait_cfg(1, 1);
        run_step(1, 1'b0, 1'b0);
        finish_chk(1);
    endtask

    task automatic t_max;
        int reqs = 0;
        do_start(15);
        for (int s = 0; s < 14; s++) begin
            run_step(s % 2, s == 0, s % 4 == 3);
            wait_cfg((s + 1) % 2, 1);
            reqs++;
        end
        run_step(0, 1'b0, 1'b0);
        finish_chk(0);
        check(reqs == 14, "R10", "requests for 15 passes", reqs, 14);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_three();
        t_zero_count();
        t_start_ignored();
        t_max();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule